// File: doc/BRIEF.md
# Frame-Synchronous Filter Coefficient Register Bank

This block is the host-facing register bank of a two-dimensional convolution filter. A word-addressed host port (address, write strobe, write data, read strobe, read data) gives access to a run/stop control word, a running-status word and one signed coefficient per kernel tap. The host may rewrite any of these at any time.

The convolution datapath never sees the live registers. When it reaches a frame boundary it pulses `frame_start`. On that edge the block copies every live coefficient into a shadow set and samples the run bit. One cycle later it answers with an acknowledge pulse that carries the sampled run bit. The shadow set drives the datapath for the whole frame. Clearing the run bit therefore stops the filter only at the next frame boundary. Until the host sets the run bit again and another `frame_start` arrives, the block holds the datapath idle.

The shadow coefficients are offered as a flat bus. A tap lookup port also returns the shadow coefficient for any tap index, together with its kernel row and column.

Top module: `fir_coef_regbank`

## Requirements
- R1: After reset, the read data is 0, the acknowledge is 0, the idle hold is 1, the status bit is 0, and all live and shadow coefficients are 0.
- R2: Word address 0 is the control word. A write stores only bit 0, the run bit. A read returns the run bit in bit 0 and zeros in bits 31..1.
- R3: Word address 1 is the status word. A read returns in bit 0 whether the filter is running, with zeros above it. Writes to it change nothing.
- R4: Coefficient k lives at word address k+2. A write stores the low COEF_W bits as a two's-complement value. A read returns the live (not shadow) value, sign-extended to 32 bits.
- R5: Addresses at or above KW*KH+2 read as zero, and writes to them change no register.
- R6: The shadow coefficients change only on a clock edge where `frame_start` is 1. On that edge they take the live values held before that edge, so a write in the same cycle is not captured.
- R7: `snap_ack` is 1 exactly in the cycle after a `frame_start` cycle. `snap_go` then equals the run bit sampled on that edge.
- R8: The status bit and the inverse of `hold_idle` change only at a `frame_start`, where they take the sampled run bit. Clearing the run bit mid-frame leaves the filter running until the next `frame_start`.
- R9: For tap index i below KW*KH, `tap_row` is i/KW, `tap_col` is i mod KW and `tap_coef` is shadow coefficient i. A larger index returns zeros on all three.
- R10: Read data is registered. It updates one cycle after a read strobe and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Word address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Registered read data |
| frame_start | input | 1 | One-cycle frame boundary request from datapath |
| snap_ack | output | 1 | Snapshot taken, one cycle after request |
| snap_go | output | 1 | Run bit sampled by the snapshot |
| hold_idle | output | 1 | Datapath must stay idle |
| tap_idx | input | IDX_W | Tap index for lookup |
| tap_coef | output | COEF_W | Shadow coefficient of that tap |
| tap_row | output | 3 | Kernel row of that tap |
| tap_col | output | 3 | Kernel column of that tap |
| shadow_coefs | output | KW*KH*COEF_W | All shadow coefficients, tap k at bits k*COEF_W upward |

## Verification
The clocked properties assume that `frame_start` is a clean one-cycle request with no X after reset, and that the address is known whenever a strobe is high. The tap mapping check assumes only that `tap_idx` is known. The bench drives every input at the falling edge from known values and never leaves a strobe floating. Its random mix spans addresses beyond the decoded range and places frame requests back to back and alongside writes, which stays inside those assumptions.

// File: rtl/fcr_pkg.sv
// Package: shared constants and decode type for the coefficient register bank.
// Assumes kernel dimensions of at most 7, so row/column fit in DIM_W bits.
package fcr_pkg;
    localparam int DATA_W    = 32;
    localparam int DIM_W     = 3;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_COEF = 2;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_COEF,
        SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/fcr_host_regs.sv
// Host-side live registers: decodes the word address, holds the run bit and
// the live coefficients, and returns registered read data.
// Assumes host_addr is stable and known while a strobe is high.
module fcr_host_regs
    import fcr_pkg::*;
#(
    parameter int NCOEF  = 9,
    parameter int COEF_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic                          host_wr,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic                          host_rd,
    input  logic                          running,
    output logic [DATA_W-1:0]             host_rdata,
    output logic                          go_q,
    output logic [NCOEF-1:0][COEF_W-1:0]  live_coefs
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_COEF0 = ADDR_W'(ADDR_COEF);
    localparam logic [ADDR_W-1:0] A_NCOEF = ADDR_W'(NCOEF);

    reg_sel_e            sel;
    logic [ADDR_W-1:0]   off;
    logic [DATA_W-1:0]   rd_word;

    // Address decode: pick the register class and the coefficient offset.
    always_comb begin
        off = host_addr - A_COEF0;
        if (host_addr == A_CTRL)                          sel = SEL_CTRL;
        else if (host_addr == A_STAT)                     sel = SEL_STAT;
        else if (host_addr >= A_COEF0 && off < A_NCOEF)   sel = SEL_COEF;
        else                                              sel = SEL_NONE;
    end

    // Run bit: only bit 0 of a control write is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                         go_q <= 1'b0;
        else if (host_wr && sel == SEL_CTRL) go_q <= host_wdata[0];
    end

    // Live coefficients: the addressed one takes the low COEF_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_coefs <= '0;
        end else if (host_wr && sel == SEL_COEF) begin
            for (int i = 0; i < NCOEF; i++)
                if (off == ADDR_W'(i)) live_coefs[i] <= host_wdata[COEF_W-1:0];
        end
    end

    // Read multiplexer: sign-extends coefficients, zero for unmapped words.
    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_CTRL: rd_word[0] = go_q;
            SEL_STAT: rd_word[0] = running;
            SEL_COEF: begin
                for (int i = 0; i < NCOEF; i++)
                    if (off == ADDR_W'(i)) rd_word = DATA_W'(signed'(live_coefs[i]));
            end
            default:  rd_word = '0;
        endcase
    end

    // Read data register: loads only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_word;
    end

    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == A_CTRL) |=> (host_rdata[DATA_W-1:1] == '0));

    p_stat_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == A_STAT) |=> (host_rdata[DATA_W-1:1] == '0));

    p_oob_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr >= A_COEF0 + A_NCOEF) |=> (host_rdata == '0));

    p_oob_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr >= A_COEF0 + A_NCOEF) |=> ($stable(live_coefs) && $stable(go_q)));

    p_rdata_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: rtl/fcr_snapshot.sv
// Frame-boundary snapshot: on frame_start copies the live coefficients into
// the shadow set, samples the run bit into the running flag and acknowledges.
// Assumes frame_start is a one-cycle pulse from the datapath.
module fcr_snapshot
    import fcr_pkg::*;
#(
    parameter int NCOEF  = 9,
    parameter int COEF_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic                          go_q,
    input  logic [NCOEF-1:0][COEF_W-1:0]  live_coefs,
    output logic [NCOEF-1:0][COEF_W-1:0]  shadow_q,
    output logic                          running,
    output logic                          snap_ack,
    output logic                          snap_go,
    output logic                          hold_idle
);
    // Shadow set and running flag: updated only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            running  <= 1'b0;
        end else if (frame_start) begin
            shadow_q <= live_coefs;
            running  <= go_q;
        end
    end

    // Acknowledge: one-cycle pulse carrying the sampled run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ack <= 1'b0;
            snap_go  <= 1'b0;
        end else begin
            snap_ack <= frame_start;
            snap_go  <= frame_start & go_q;
        end
    end

    // Idle hold: the datapath waits whenever the last sample said stop.
    always_comb hold_idle = ~running;

    p_ack_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (snap_ack && snap_go == $past(go_q)));

    p_ack_only_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> !snap_ack);

    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(shadow_q));

    p_shadow_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (shadow_q == $past(live_coefs)));

    p_status_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (running == $past(go_q) && hold_idle == !$past(go_q)));

    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(running));
endmodule

// File: rtl/fcr_tap_map.sv
// Tap lookup: maps a tap index to its kernel row/column and returns the
// shadow coefficient of that tap. Row/column tables are built per tap.
// Assumes KW <= 7 and the number of rows <= 7.
module fcr_tap_map
    import fcr_pkg::*;
#(
    parameter int NCOEF  = 9,
    parameter int KW     = 3,
    parameter int COEF_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]              tap_idx,
    input  logic [NCOEF-1:0][COEF_W-1:0]  shadow_q,
    output logic [COEF_W-1:0]             tap_coef,
    output logic [DIM_W-1:0]              tap_row,
    output logic [DIM_W-1:0]              tap_col
);
    logic [DIM_W-1:0] row_lut [NCOEF];
    logic [DIM_W-1:0] col_lut [NCOEF];

    for (genvar i = 0; i < NCOEF; i++) begin : g_tap
        localparam int ROW = i / KW;
        localparam int COL = i % KW;
        assign row_lut[i] = DIM_W'(ROW);
        assign col_lut[i] = DIM_W'(COL);
    end

    // Index select: zeros for an index beyond the last tap.
    always_comb begin
        tap_coef = '0;
        tap_row  = '0;
        tap_col  = '0;
        for (int i = 0; i < NCOEF; i++) begin
            if (tap_idx == IDX_W'(i)) begin
                tap_coef = shadow_q[i];
                tap_row  = row_lut[i];
                tap_col  = col_lut[i];
            end
        end
    end

    // Mapping check: row and column recombine to the index, column below KW.
    always_comb begin
        if (!$isunknown(tap_idx) && int'(tap_idx) < NCOEF) begin
            p_tap_recombine_r9: assert ((int'(tap_row) * KW + int'(tap_col)) == int'(tap_idx)
                                        && int'(tap_col) < KW);
        end
    end
endmodule

// File: rtl/fir_coef_regbank.sv
// Top: coefficient register bank for a 2-D convolution filter. The host
// writes live registers. The datapath sees only the shadow set, which is
// refreshed on each frame_start.
// Assumes 3 <= KW, KH <= 7 and that ADDR_W covers KW*KH+2 words.
module fir_coef_regbank
    import fcr_pkg::*;
#(
    parameter  int KW     = 3,
    parameter  int KH     = 3,
    parameter  int COEF_W = 16,
    parameter  int ADDR_W = 6,
    localparam int NCOEF  = KW * KH,
    localparam int IDX_W  = $clog2(NCOEF + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic                      host_wr,
    input  logic [31:0]               host_wdata,
    input  logic                      host_rd,
    output logic [31:0]               host_rdata,
    input  logic                      frame_start,
    output logic                      snap_ack,
    output logic                      snap_go,
    output logic                      hold_idle,
    input  logic [IDX_W-1:0]          tap_idx,
    output logic [COEF_W-1:0]         tap_coef,
    output logic [2:0]                tap_row,
    output logic [2:0]                tap_col,
    output logic [NCOEF*COEF_W-1:0]   shadow_coefs
);
    logic                          go_q;
    logic                          running;
    logic [NCOEF-1:0][COEF_W-1:0]  live_coefs;
    logic [NCOEF-1:0][COEF_W-1:0]  shadow_q;

    fcr_host_regs #(.NCOEF(NCOEF), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .running    (running),
        .host_rdata (host_rdata),
        .go_q       (go_q),
        .live_coefs (live_coefs)
    );

    fcr_snapshot #(.NCOEF(NCOEF), .COEF_W(COEF_W)) u_snap (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .go_q        (go_q),
        .live_coefs  (live_coefs),
        .shadow_q    (shadow_q),
        .running     (running),
        .snap_ack    (snap_ack),
        .snap_go     (snap_go),
        .hold_idle   (hold_idle)
    );

    fcr_tap_map #(.NCOEF(NCOEF), .KW(KW), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_map (
        .tap_idx  (tap_idx),
        .shadow_q (shadow_q),
        .tap_coef (tap_coef),
        .tap_row  (tap_row),
        .tap_col  (tap_col)
    );

    // Flatten the shadow set for the datapath.
    always_comb shadow_coefs = shadow_q;
endmodule

// File: tb/tb_fir_coef_regbank.sv
module tb_fir_coef_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int KW     = 4;
    localparam int KH     = 3;
    localparam int COEF_W = 16;
    localparam int ADDR_W = 6;
    localparam int NCOEF  = KW * KH;
    localparam int NADDR  = NCOEF + 2;
    localparam int IDX_W  = $clog2(NCOEF + 1);

    logic                     clk = 0;
    logic                     rst_n = 0;
    logic [ADDR_W-1:0]        host_addr = '0;
    logic                     host_wr = 0;
    logic [31:0]              host_wdata = '0;
    logic                     host_rd = 0;
    logic [31:0]              host_rdata;
    logic                     frame_start = 0;
    logic                     snap_ack, snap_go, hold_idle;
    logic [IDX_W-1:0]         tap_idx = '0;
    logic [COEF_W-1:0]        tap_coef;
    logic [2:0]               tap_row, tap_col;
    logic [NCOEF*COEF_W-1:0]  shadow_coefs;

    int nchk = 0;
    int nerr = 0;

    logic [COEF_W-1:0] live_m   [NCOEF];
    logic [COEF_W-1:0] shadow_m [NCOEF];
    logic              go_m  = 0;
    logic              run_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_coef_regbank #(.KW(KW), .KH(KH), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .frame_start(frame_start), .snap_ack(snap_ack), .snap_go(snap_go),
        .hold_idle(hold_idle), .tap_idx(tap_idx), .tap_coef(tap_coef),
        .tap_row(tap_row), .tap_col(tap_col), .shadow_coefs(shadow_coefs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [COEF_W-1:0] v);
        return 32'(signed'(v));
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        if (a == 0) return {31'b0, go_m};
        if (a == 1) return {31'b0, run_m};
        if (a >= 2 && a < NADDR) return sx(live_m[a-2]);
        return 32'h0;
    endfunction

    // Model update for a host write (R2, R3, R4, R5 rules).
    task automatic model_write(input int a, input logic [31:0] d);
        if (a == 0) go_m = d[0];
        else if (a >= 2 && a < NADDR) live_m[a-2] = d[COEF_W-1:0];
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        host_addr = ADDR_W'(a); host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
        model_write(a, d);
    endtask

    task automatic host_read(input int a, input string tag);
        logic [31:0] e;
        e = exp_read(a);
        host_addr = ADDR_W'(a); host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        chk(tag, host_rdata, e);
        chk("R7 no ack without request", {31'b0, snap_ack}, 32'h0);
    endtask

    task automatic check_shadow(input string tag);
        for (int k = 0; k < NCOEF; k++)
            chk(tag, {16'b0, shadow_coefs[k*COEF_W +: COEF_W]}, {16'b0, shadow_m[k]});
    endtask

    // Frame request, optionally with a host write in the same cycle (R6).
    task automatic frame(input bit with_wr, input int a, input logic [31:0] d);
        logic g;
        g = go_m;
        frame_start = 1;
        if (with_wr) begin host_addr = ADDR_W'(a); host_wdata = d; host_wr = 1; end
        @(negedge clk);
        frame_start = 0; host_wr = 0;
        for (int k = 0; k < NCOEF; k++) shadow_m[k] = live_m[k];
        run_m = g;
        if (with_wr) model_write(a, d);
        chk("R7 ack pulse", {31'b0, snap_ack}, 32'h1);
        chk("R7 sampled go", {31'b0, snap_go}, {31'b0, g});
        chk("R8 hold_idle", {31'b0, hold_idle}, {31'b0, ~g});
        check_shadow("R6 shadow capture");
    endtask

    task automatic tap_check(input int i);
        tap_idx = IDX_W'(i);
        #1;
        if (i < NCOEF) begin
            chk("R9 row", {29'b0, tap_row}, 32'(i / KW));
            chk("R9 col", {29'b0, tap_col}, 32'(i % KW));
            chk("R9 coef", {16'b0, tap_coef}, {16'b0, shadow_m[i]});
        end else begin
            chk("R9 oob tap", {13'b0, tap_row, tap_col, tap_coef}, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NCOEF; k++) begin live_m[k] = '0; shadow_m[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 ack", {31'b0, snap_ack}, 32'h0);
        chk("R1 hold_idle", {31'b0, hold_idle}, 32'h1);
        check_shadow("R1 shadow zero");
        host_read(1, "R1 status zero");
        host_read(5, "R1 live coef zero");

        // R2: control word keeps only bit 0
        host_write(0, 32'hFFFF_FFFF);
        host_read(0, "R2 ctrl set");
        host_write(0, 32'hFFFF_FFFE);
        host_read(0, "R2 ctrl upper ignored");

        // R3: status write has no effect
        host_write(1, 32'hFFFF_FFFF);
        host_read(1, "R3 status unwritable");

        // R4: signed coefficients, sign extension
        host_write(2, 32'h0001_8001);
        host_read(2, "R4 negative sext");
        host_write(NADDR-1, 32'hABCD_7FFF);
        host_read(NADDR-1, "R4 last coef");

        // R5: out of range
        host_write(NADDR, 32'h1234_5678);
        host_write(63, 32'hFFFF_FFFF);
        host_read(NADDR, "R5 oob read zero");
        host_read(63, "R5 top read zero");
        for (int a = 0; a < NADDR; a++) host_read(a, "R5 no side effect");

        // R10: read data held without strobe
        host_read(2, "R10 read");
        held = host_rdata;
        host_write(2, 32'h0000_0042);
        host_addr = ADDR_W'(3);
        @(negedge clk);
        chk("R10 rdata held", host_rdata, held);

        // R6/R7/R8: start running, mid-frame writes do not reach shadow
        host_write(0, 32'h1);
        host_read(1, "R8 not running before frame");
        frame(0, 0, 0);
        host_read(1, "R8 running after frame");
        host_write(3, 32'h0000_F00D);
        check_shadow("R6 mid-frame write isolated");
        host_read(3, "R4 live read after write");

        // R8: stop takes effect at next frame
        host_write(0, 32'h0);
        host_read(1, "R8 still running");
        chk("R8 no idle yet", {31'b0, hold_idle}, 32'h0);
        frame(0, 0, 0);
        host_read(1, "R8 stopped");
        frame(0, 0, 0);
        chk("R8 stays idle", {31'b0, hold_idle}, 32'h1);

        // R6: write coinciding with frame_start is not captured
        host_write(0, 32'h1);
        frame(1, 4, 32'h0000_1357);
        host_read(4, "R6 coincident write reaches live");
        frame(0, 0, 0);

        // R9: tap sweep
        for (int i = 0; i <= NCOEF; i++) tap_check(i);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            int a;
            op = int'($urandom % 6);
            a  = int'($urandom % (NADDR + 4));
            case (op)
                0, 1: host_write(a, $urandom);
                2:    host_write(0, {31'b0, 1'($urandom)});
                3:    host_read(a, "R4 random read");
                4:    frame(1'($urandom), a, $urandom);
                default: tap_check(int'($urandom % (NCOEF + 1)));
            endcase
        end
        check_shadow("R6 final shadow");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule